// File: doc/BRIEF.md
# Edge-Latched Maskable Interrupt Unit

This block collects events from a set of external interrupt lines, eight by default. Each line is first brought into the clock domain. Its active edge, rising or falling, is then detected and held in a per-line latch. Software reads the raw latches and a masked view of them, clears latches one at a time by writing ones, and sets a global enable that gates a single interrupt request output. An acknowledge input makes the block present a programmable 8-bit vector on its read data bus.

Access goes through a small register port. Writes take effect on the clock edge that samples them. Reads return data on the cycle after the read strobe. The acknowledge path is a three-state machine: ACK_IDLE, ACK_PRESENT and ACK_RELEASE. On IDLE_TO_PRESENT, iack is sampled high in ACK_IDLE. PRESENT_TO_RELEASE happens when iack is still high after the single presentation cycle. PRESENT_TO_IDLE happens when iack has already dropped. RELEASE_TO_IDLE happens once iack falls. RELEASE_HOLD keeps the machine in ACK_RELEASE while iack stays high, so a new presentation needs iack to go low first.

Top module: `edge_irq_unit`

## Requirements
- R1: Register 86h holds one edge-select bit per line: 1 means rising edge, 0 means falling edge. It resets to all ones. A transition of the selected polarity sets the line's latch at the third rising clock edge after the transition. A transition of the other polarity leaves the latch unchanged.
- R2: A set latch bit stays 1 until software clears it. Further edges on that line have no effect while it is set.
- R3: Writing register 84h clears every latch whose data bit is 1, on the clock edge of the write. Data bits of 0 leave their latches alone. If a detected edge and a clear of the same bit fall in the same cycle, the bit ends up set.
- R4: Register 80h reads the raw latches, including those of masked lines.
- R5: Register 82h reads the latches ANDed with the mask. The mask is register 83h, read/write, reset 0.
- R6: Register 81h bit 2 reads 1 exactly when some pending bit is 1. Bit 0 is the global enable, read/write, reset 0. All other bits read 0, and writes to them are ignored.
- R7: The output irq is 1 exactly when the global enable is 1 and some pending bit is 1. Turning the enable off does not clear any latch.
- R8: Register 85h is the read/write 8-bit vector and has no reset value. When iack is sampled high in ACK_IDLE, vec_valid is 1 for the following cycle, and bus_rdata then carries the vector. The next presentation requires iack to be low for at least one clock edge first.
- R9: bus_rdata carries the value of the addressed register during the cycle after a bus_rd strobe, and is 0 otherwise outside ACK_PRESENT. Register 84h and unmapped addresses read 0.
- R10: After reset, irq, vec_valid and bus_rdata are 0, and the latches, mask and enable are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_lines | input | NUM_LINES | Asynchronous interrupt input lines |
| bus_addr | input | 8 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | NUM_LINES | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | NUM_LINES | Read data, or the vector while presenting |
| iack | input | 1 | Interrupt acknowledge |
| vec_valid | output | 1 | Vector is being presented on bus_rdata |
| irq | output | 1 | Interrupt request |

## Verification
Lines are driven with rising transitions, falling transitions and repeated toggles on lines that are already latched. This separates correct edge polarity from level sensitivity, and a sticky latch from one that retriggers. The mask and enable are changed while a latch is held, which shows that the raw view, the pending view and the request each respond to their own controls. A clear is timed to land in the same cycle as a fresh edge to test the set-wins rule. Back-to-back acknowledges show that the vector is presented only once per iack pulse.

// File: rtl/edge_irq_pkg.sv
package edge_irq_pkg;

    typedef enum logic [1:0] {
        ACK_IDLE    = 2'd0,
        ACK_PRESENT = 2'd1,
        ACK_RELEASE = 2'd2
    } ack_state_e;

    localparam logic [7:0] OFS_LATCH   = 8'h80;
    localparam logic [7:0] OFS_STATUS  = 8'h81;
    localparam logic [7:0] OFS_PENDING = 8'h82;
    localparam logic [7:0] OFS_MASK    = 8'h83;
    localparam logic [7:0] OFS_CLEAR   = 8'h84;
    localparam logic [7:0] OFS_VECTOR  = 8'h85;
    localparam logic [7:0] OFS_EDGESEL = 8'h86;

    localparam int STATUS_EN_BIT   = 0;
    localparam int STATUS_PEND_BIT = 2;

endpackage

// File: rtl/edge_irq_sync_detect.sv
module edge_irq_sync_detect #(
    parameter int NUM_LINES   = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] lines_in,
    input  logic [NUM_LINES-1:0] rise_sel,
    output logic [NUM_LINES-1:0] edge_pulse
);

    localparam int LAST = SYNC_STAGES - 1;

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        logic [SYNC_STAGES-1:0] chain;
        logic                   prev;
        logic                   cur;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chain <= '0;
                prev  <= 1'b0;
            end else begin
                chain <= {chain[SYNC_STAGES-2:0], lines_in[g]};
                prev  <= chain[LAST];
            end
        end

        assign cur = chain[LAST];

        always_comb begin
            if (rise_sel[g]) begin
                edge_pulse[g] = cur & ~prev;
            end else begin
                edge_pulse[g] = ~cur & prev;
            end
        end
    end

endmodule

// File: rtl/edge_irq_latch_bank.sv
module edge_irq_latch_bank #(
    parameter int NUM_LINES = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] edge_pulse,
    input  logic [NUM_LINES-1:0] clr_vec,
    input  logic [NUM_LINES-1:0] mask,
    output logic [NUM_LINES-1:0] latched,
    output logic [NUM_LINES-1:0] pending,
    output logic                 any_pending
);

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_bit
        logic held;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                held <= 1'b0;
            end else if (edge_pulse[g]) begin
                held <= 1'b1;
            end else if (clr_vec[g]) begin
                held <= 1'b0;
            end
        end

        assign latched[g] = held;
        assign pending[g] = held & mask[g];
    end

    assign any_pending = |pending;

endmodule

// File: rtl/edge_irq_regs.sv
module edge_irq_regs
    import edge_irq_pkg::*;
#(
    parameter int NUM_LINES = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [7:0]           bus_addr,
    input  logic                 bus_wr,
    input  logic [NUM_LINES-1:0] bus_wdata,
    input  logic                 bus_rd,
    input  logic [NUM_LINES-1:0] latched,
    input  logic [NUM_LINES-1:0] pending,
    input  logic                 any_pending,
    output logic [NUM_LINES-1:0] mask,
    output logic [NUM_LINES-1:0] rise_sel,
    output logic [NUM_LINES-1:0] vector,
    output logic [NUM_LINES-1:0] clr_vec,
    output logic                 global_en,
    output logic [NUM_LINES-1:0] rd_q
);

    logic                 wr_status;
    logic                 wr_mask;
    logic                 wr_vector;
    logic                 wr_edgesel;
    logic [NUM_LINES-1:0] status_word;
    logic [NUM_LINES-1:0] rd_mux;

    assign wr_status  = bus_wr && (bus_addr == OFS_STATUS);
    assign wr_mask    = bus_wr && (bus_addr == OFS_MASK);
    assign wr_vector  = bus_wr && (bus_addr == OFS_VECTOR);
    assign wr_edgesel = bus_wr && (bus_addr == OFS_EDGESEL);
    assign clr_vec    = (bus_wr && (bus_addr == OFS_CLEAR)) ? bus_wdata : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask      <= '0;
            rise_sel  <= '1;
            global_en <= 1'b0;
        end else begin
            if (wr_mask) begin
                mask <= bus_wdata;
            end
            if (wr_edgesel) begin
                rise_sel <= bus_wdata;
            end
            if (wr_status) begin
                global_en <= bus_wdata[STATUS_EN_BIT];
            end
        end
    end

    // The vector has no reset value: software programs it before use.
    always_ff @(posedge clk) begin
        if (wr_vector) begin
            vector <= bus_wdata;
        end
    end

    always_comb begin
        status_word                  = '0;
        status_word[STATUS_EN_BIT]   = global_en;
        status_word[STATUS_PEND_BIT] = any_pending;
    end

    always_comb begin
        unique case (bus_addr)
            OFS_LATCH:   rd_mux = latched;
            OFS_STATUS:  rd_mux = status_word;
            OFS_PENDING: rd_mux = pending;
            OFS_MASK:    rd_mux = mask;
            OFS_VECTOR:  rd_mux = vector;
            OFS_EDGESEL: rd_mux = rise_sel;
            default:     rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else begin
            rd_q <= bus_rd ? rd_mux : '0;
        end
    end

endmodule

// File: rtl/edge_irq_ack_fsm.sv
module edge_irq_ack_fsm
    import edge_irq_pkg::*;
#(
    parameter int NUM_LINES = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 iack,
    input  logic [NUM_LINES-1:0] vector,
    input  logic [NUM_LINES-1:0] rd_q,
    output logic                 vec_valid,
    output logic [NUM_LINES-1:0] bus_rdata
);

    ack_state_e state;
    ack_state_e state_nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ACK_IDLE;
        end else begin
            state <= state_nxt;
        end
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            ACK_IDLE:    if (iack) state_nxt = ACK_PRESENT;            // IDLE_TO_PRESENT
            ACK_PRESENT: state_nxt = iack ? ACK_RELEASE : ACK_IDLE;    // PRESENT_TO_RELEASE / PRESENT_TO_IDLE
            ACK_RELEASE: if (!iack) state_nxt = ACK_IDLE;              // RELEASE_TO_IDLE, else RELEASE_HOLD
            default:     state_nxt = ACK_IDLE;
        endcase
    end

    always_comb begin
        vec_valid = 1'b0;
        bus_rdata = rd_q;
        unique case (state)
            ACK_PRESENT: begin
                vec_valid = 1'b1;
                bus_rdata = vector;
            end
            ACK_IDLE, ACK_RELEASE: begin
                vec_valid = 1'b0;
                bus_rdata = rd_q;
            end
            default: begin
                vec_valid = 1'b0;
                bus_rdata = rd_q;
            end
        endcase
    end

endmodule

// File: rtl/edge_irq_unit.sv
module edge_irq_unit
    import edge_irq_pkg::*;
#(
    parameter int NUM_LINES   = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] irq_lines,
    input  logic [7:0]           bus_addr,
    input  logic                 bus_wr,
    input  logic [NUM_LINES-1:0] bus_wdata,
    input  logic                 bus_rd,
    output logic [NUM_LINES-1:0] bus_rdata,
    input  logic                 iack,
    output logic                 vec_valid,
    output logic                 irq
);

    logic [NUM_LINES-1:0] edge_pulse;
    logic [NUM_LINES-1:0] rise_sel;
    logic [NUM_LINES-1:0] clr_vec;
    logic [NUM_LINES-1:0] mask;
    logic [NUM_LINES-1:0] latched;
    logic [NUM_LINES-1:0] pending;
    logic [NUM_LINES-1:0] vector;
    logic [NUM_LINES-1:0] rd_q;
    logic                 any_pending;
    logic                 global_en;

    edge_irq_sync_detect #(
        .NUM_LINES  (NUM_LINES),
        .SYNC_STAGES(SYNC_STAGES)
    ) u_detect (
        .clk       (clk),
        .rst_n     (rst_n),
        .lines_in  (irq_lines),
        .rise_sel  (rise_sel),
        .edge_pulse(edge_pulse)
    );

    edge_irq_latch_bank #(
        .NUM_LINES(NUM_LINES)
    ) u_latch (
        .clk        (clk),
        .rst_n      (rst_n),
        .edge_pulse (edge_pulse),
        .clr_vec    (clr_vec),
        .mask       (mask),
        .latched    (latched),
        .pending    (pending),
        .any_pending(any_pending)
    );

    edge_irq_regs #(
        .NUM_LINES(NUM_LINES)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_addr   (bus_addr),
        .bus_wr     (bus_wr),
        .bus_wdata  (bus_wdata),
        .bus_rd     (bus_rd),
        .latched    (latched),
        .pending    (pending),
        .any_pending(any_pending),
        .mask       (mask),
        .rise_sel   (rise_sel),
        .vector     (vector),
        .clr_vec    (clr_vec),
        .global_en  (global_en),
        .rd_q       (rd_q)
    );

    edge_irq_ack_fsm #(
        .NUM_LINES(NUM_LINES)
    ) u_ack (
        .clk      (clk),
        .rst_n    (rst_n),
        .iack     (iack),
        .vector   (vector),
        .rd_q     (rd_q),
        .vec_valid(vec_valid),
        .bus_rdata(bus_rdata)
    );

    assign irq = any_pending & global_en;

endmodule

// File: rtl/edge_irq_unit_chk.sv
module edge_irq_unit_chk #(
    parameter int NUM_LINES = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 iack,
    input logic                 vec_valid,
    input logic                 irq,
    input logic                 global_en,
    input logic [NUM_LINES-1:0] bus_rdata,
    input logic [NUM_LINES-1:0] vector,
    input logic [NUM_LINES-1:0] latched,
    input logic [NUM_LINES-1:0] edge_pulse,
    input logic [NUM_LINES-1:0] clr_vec
);

    // R2 / R3: a latch bit only drops when a clear of that bit was written
    assert_latch_drop_needs_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(latched) & ~latched & ~$past(clr_vec)) == '0));

    // R2 / R1: a latch bit only rises after a detected edge
    assert_latch_rise_needs_edge_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((latched & ~$past(latched) & ~$past(edge_pulse)) == '0));

    // R7: no request while globally disabled
    assert_irq_needs_enable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !global_en |-> !irq);

    // R8: a presentation lasts exactly one cycle
    assert_vec_single_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |=> !vec_valid);

    // R8: a presentation starts only after iack was sampled
    assert_vec_after_iack_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vec_valid) |-> $past(iack));

    // R8: the read bus carries the vector while presenting
    assert_vec_on_bus_R8: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |-> (bus_rdata == vector));

endmodule

bind edge_irq_unit edge_irq_unit_chk #(.NUM_LINES(NUM_LINES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .iack      (iack),
    .vec_valid (vec_valid),
    .irq       (irq),
    .global_en (global_en),
    .bus_rdata (bus_rdata),
    .vector    (vector),
    .latched   (latched),
    .edge_pulse(edge_pulse),
    .clr_vec   (clr_vec)
);

// File: tb/edge_irq_unit_bench.sv
module edge_irq_unit_bench;

    localparam int CLK_PERIOD = 10;
    localparam int N          = 8;
    localparam int WATCHDOG   = 20000;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] irq_lines = '0;
    logic [7:0]   bus_addr = '0;
    logic         bus_wr = 1'b0;
    logic [N-1:0] bus_wdata = '0;
    logic         bus_rd = 1'b0;
    logic [N-1:0] bus_rdata;
    logic         iack = 1'b0;
    logic         vec_valid;
    logic         irq;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    edge_irq_unit #(.NUM_LINES(N)) u_edge_irq_unit (
        .clk      (clk),
        .rst_n    (rst_n),
        .irq_lines(irq_lines),
        .bus_addr (bus_addr),
        .bus_wr   (bus_wr),
        .bus_wdata(bus_wdata),
        .bus_rd   (bus_rd),
        .bus_rdata(bus_rdata),
        .iack     (iack),
        .vec_valid(vec_valid),
        .irq      (irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // ---------------- behavioural reference model ----------------
    bit [N-1:0] m_s1, m_s2, m_prev, m_latch, m_mask, m_sel, m_vec, m_rdq;
    bit         m_en;
    int         m_state;   // 0 idle, 1 presenting, 2 waiting for release

    function automatic bit [N-1:0] m_read(input bit [7:0] a);
        bit [N-1:0] r;
        r = '0;
        if (a == 8'h80) r = m_latch;
        else if (a == 8'h81) begin r[2] = |(m_latch & m_mask); r[0] = m_en; end
        else if (a == 8'h82) r = m_latch & m_mask;
        else if (a == 8'h83) r = m_mask;
        else if (a == 8'h85) r = m_vec;
        else if (a == 8'h86) r = m_sel;
        return r;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_s1 <= '0; m_s2 <= '0; m_prev <= '0; m_latch <= '0;
            m_mask <= '0; m_sel <= '1; m_en <= 1'b0; m_rdq <= '0; m_state <= 0;
        end else begin
            bit [N-1:0] ev;
            bit [N-1:0] clr;
            for (int i = 0; i < N; i++)
                ev[i] = m_sel[i] ? (m_s2[i] && !m_prev[i]) : (!m_s2[i] && m_prev[i]);
            clr = (bus_wr && bus_addr == 8'h84) ? bus_wdata : '0;
            m_s1 <= irq_lines; m_s2 <= m_s1; m_prev <= m_s2;
            m_latch <= (m_latch & ~clr) | ev;
            if (bus_wr && bus_addr == 8'h83) m_mask <= bus_wdata;
            if (bus_wr && bus_addr == 8'h86) m_sel <= bus_wdata;
            if (bus_wr && bus_addr == 8'h85) m_vec <= bus_wdata;
            if (bus_wr && bus_addr == 8'h81) m_en <= bus_wdata[0];
            m_rdq <= bus_rd ? m_read(bus_addr) : '0;
            if (m_state == 0) m_state <= iack ? 1 : 0;
            else if (m_state == 1) m_state <= iack ? 2 : 0;
            else m_state <= iack ? 2 : 0;
        end
    end

    task automatic check(input string tag, input logic [N-1:0] got, input logic [N-1:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h at cycle %0d", tag, got, exp, cycles);
        end
    endtask

    // per-cycle comparison against the model, away from the active edge
    always @(negedge clk) begin
        cycles++;
        if (rst_n) begin
            check("R7 irq vs model", {{(N-1){1'b0}}, irq},
                  {{(N-1){1'b0}}, m_en && |(m_latch & m_mask)});
            check("R8 vec_valid vs model", {{(N-1){1'b0}}, vec_valid},
                  {{(N-1){1'b0}}, m_state == 1});
            check("R9 bus_rdata vs model", bus_rdata, (m_state == 1) ? m_vec : m_rdq);
        end
        if (cycles > WATCHDOG) begin
            errors++;
            $display("FAIL watchdog: got %0d cycles expected under %0d", cycles, WATCHDOG);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // ---------------- stimulus tasks ----------------
    task automatic wr(input logic [7:0] a, input logic [N-1:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [N-1:0] exp, input string tag);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_rd = 1'b0;
        check(tag, bus_rdata, exp);
    endtask

    task automatic set_line(input int idx, input logic v);
        @(negedge clk);
        irq_lines[idx] = v;
    endtask

    task automatic chk_bit(input string tag, input logic got, input logic exp);
        check(tag, {{(N-1){1'b0}}, got}, {{(N-1){1'b0}}, exp});
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R10 reset state
        chk_bit("R10 irq after reset", irq, 1'b0);
        chk_bit("R10 vec_valid after reset", vec_valid, 1'b0);
        check("R10 rdata after reset", bus_rdata, 8'h00);
        rd(8'h80, 8'h00, "R10 latches reset");
        rd(8'h81, 8'h00, "R10 status reset");
        rd(8'h83, 8'h00, "R10 mask reset");
        rd(8'h86, 8'hFF, "R1 edge select reset all rising");
        rd(8'h84, 8'h00, "R9 clear register reads 0");
        rd(8'h10, 8'h00, "R9 unmapped reads 0");

        // R8 vector programming
        wr(8'h85, 8'h5A);
        rd(8'h85, 8'h5A, "R8 vector readback");
        wr(8'h83, 8'h0F);

        // R1 R4 R5 R6 rising edges on lines 0 and 5
        set_line(0, 1'b1);
        set_line(5, 1'b1);
        repeat (4) @(posedge clk);
        rd(8'h80, 8'h21, "R4 raw latches include masked line");
        rd(8'h82, 8'h01, "R5 pending is latch AND mask");
        rd(8'h81, 8'h04, "R6 status pending bit");
        chk_bit("R7 irq low while disabled", irq, 1'b0);
        wr(8'h81, 8'hFE);
        chk_bit("R6 only bit0 of status writable", irq, 1'b0);
        wr(8'h81, 8'h01);
        chk_bit("R7 irq high when enabled", irq, 1'b1);
        rd(8'h81, 8'h05, "R6 status enable and pending");

        // R2 further toggles have no effect
        set_line(0, 1'b0);
        repeat (4) @(posedge clk);
        set_line(0, 1'b1);
        repeat (4) @(posedge clk);
        rd(8'h80, 8'h21, "R2 latch sticky under toggles");

        // R3 write-one-to-clear
        wr(8'h84, 8'h20);
        rd(8'h80, 8'h01, "R3 clear bit5 only");
        wr(8'h84, 8'h00);
        rd(8'h80, 8'h01, "R3 zero write has no effect");

        // R8 acknowledge sequence
        @(negedge clk); iack = 1'b1;
        @(posedge clk); @(negedge clk);
        chk_bit("R8 vec_valid on ack", vec_valid, 1'b1);
        check("R8 vector on bus", bus_rdata, 8'h5A);
        @(posedge clk); @(negedge clk);
        chk_bit("R8 no repeat while iack held", vec_valid, 1'b0);
        iack = 1'b0;
        @(posedge clk); @(negedge clk);
        iack = 1'b1;
        @(posedge clk); @(negedge clk);
        chk_bit("R8 second ack presents again", vec_valid, 1'b1);
        iack = 1'b0;

        // R7 enable off keeps latches, mask controls pending
        wr(8'h81, 8'h00);
        chk_bit("R7 irq drops on disable", irq, 1'b0);
        rd(8'h82, 8'h01, "R7 pending kept while disabled");
        wr(8'h83, 8'h00);
        rd(8'h82, 8'h00, "R5 mask zero hides pending");
        rd(8'h80, 8'h01, "R4 masked latch still visible");
        wr(8'h83, 8'h0F);
        wr(8'h81, 8'h01);
        chk_bit("R7 irq returns on enable", irq, 1'b1);
        wr(8'h84, 8'h01);
        chk_bit("R3 irq drops after clear", irq, 1'b0);
        rd(8'h80, 8'h00, "R3 latch cleared");

        // R1 falling edge on line 1
        wr(8'h86, 8'hFD);
        set_line(1, 1'b1);
        repeat (4) @(posedge clk);
        rd(8'h80, 8'h00, "R1 rising ignored in falling mode");
        set_line(1, 1'b0);
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R1 latch not yet set before third edge", {{(N-1){1'b0}}, irq}, 8'h00);
        repeat (2) @(posedge clk);
        rd(8'h80, 8'h02, "R1 falling edge latched");

        // R3 edge and clear in the same cycle: set wins
        set_line(2, 1'b1);
        repeat (2) @(posedge clk);
        wr(8'h84, 8'h04);
        rd(8'h80, 8'h06, "R3 simultaneous edge wins over clear");
        wr(8'h84, 8'h06);
        rd(8'h80, 8'h00, "R3 clear of two bits");
        chk_bit("R7 irq low after clearing all", irq, 1'b0);

        repeat (3) @(posedge clk);
        @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule